// File: doc/BRIEF.md
# Interrupt Vector Offset Encoder

This unit sits beside a soft processor's ALU as a custom-instruction datapath. The exception handler issues it once on entry. It turns the set of active, unmasked interrupt lines into a byte offset into a table of handler pointers, with one 8-byte slot per line. The handler adds that offset to the table base and jumps there. No table lookup or bit-scan loop runs in software.

When the exception did not come from hardware, the unit returns all ones instead. That happens when no line is pending, or when the saved interrupt-enable bit shows interrupts were off. Because all ones is negative, a single signed branch on the result sends the handler to its trap path.

The unit watches the instruction word presented with each start pulse. It answers only to its own opcode, selector and register-usage flags, and it reports the destination register index with the result. The operation is single-cycle: done and result are valid in the same cycle as start.

Top module: `ivo_vector_encoder`

## Requirements
- R1: The pending word is the bitwise AND of `irq_req` and `irq_mask`; a line whose mask bit is 0 is never chosen.
- R2: Among pending lines, the lowest-numbered one wins.
- R3: When a line wins, `result` equals 8 times its number, zero-extended to 32 bits (line 0 gives 0, line 31 gives 248).
- R4: When the pending word is zero, `result` is 0xFFFFFFFF.
- R5: When `saved_ie` is 0, `result` is 0xFFFFFFFF whatever the pending word holds.
- R6: The unit responds only when all three of the following hold. Otherwise `done` stays 0 and `result` is 0.
  - `instr[5:0]` is 0x32.
  - `instr[13:6]` equals parameter `SEL`.
  - `instr[16:14]` is 3'b001, where bit 14 means "writes rC" and bits 16 and 15 mean "reads rA" and "reads rB".
- R7: The source fields `instr[31:27]` and `instr[26:22]` have no effect on `done`, `result` or `wr_index`.
- R8: While `done` is 1, `wr_index` equals `instr[21:17]`. While `done` is 0, `wr_index` is 0.
- R9: `done` is 1 in exactly the cycles where `start` is 1 and the instruction matches (R6). When `done` is 0, `result` is 0.
- R10: While `rst` is 1, `done` is 0 and `result` is 0, even with a matching start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction issue strobe |
| instr | input | 32 | Custom-instruction word |
| irq_req | input | NLINES | Raw interrupt requests |
| irq_mask | input | NLINES | Per-line enable mask |
| saved_ie | input | 1 | Saved previous interrupt-enable bit |
| done | output | 1 | Completion strobe, same cycle as start |
| result | output | 32 | Table byte offset, or all ones for no interrupt |
| wr_index | output | 5 | Destination register index |

## Verification
The bench builds two copies of the unit:
- A full 32-line copy with selector 0x2A. This reaches the extreme offsets 0 and 248 and covers priority across the whole word.
- A 5-line copy with selector 0x03. This checks that a narrow line count still scales offsets correctly up to 32, and that a second selector value decodes.

On both copies the bench runs random request, mask and enable patterns. It also flips single bits of the opcode, selector and flag fields, and randomises the ignored source fields.

// File: rtl/ivo_pkg.sv
package ivo_pkg;
  localparam logic [5:0]  CI_OPCODE   = 6'h32;
  localparam logic [2:0]  CI_FLAGS    = 3'b001;
  localparam logic [31:0] NO_IRQ_CODE = 32'hFFFF_FFFF;

  typedef struct packed {
    logic [4:0] src_a;
    logic [4:0] src_b;
    logic [4:0] dst_c;
    logic [2:0] use_flags;
    logic [7:0] sel;
    logic [5:0] opcode;
  } ci_word_t;
endpackage

// File: rtl/ivo_decode.sv
module ivo_decode
  import ivo_pkg::*;
#(
  parameter logic [7:0] SEL = 8'h00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] instr,
  output logic        hit,
  output logic [4:0]  dst
);
  ci_word_t w;

  always_comb begin
    w   = ci_word_t'(instr);
    hit = (w.opcode == CI_OPCODE) && (w.sel == SEL) && (w.use_flags == CI_FLAGS);
    dst = w.dst_c;
  end

  p_hit_opcode_r6: assert property (@(posedge clk) disable iff (rst)
    hit |-> (instr[5:0] == 6'h32 && instr[16:14] == 3'b001));
endmodule

// File: rtl/ivo_prio.sv
module ivo_prio #(
  parameter int NLINES = 32,
  localparam int IDXW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] pending,
  output logic              found,
  output logic [IDXW-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (pending[i]) begin
        found = 1'b1;
        idx   = IDXW'(i);
      end
    end
  end

  logic [NLINES-1:0] below;
  always_comb begin
    for (int i = 0; i < NLINES; i++) below[i] = (i < int'(idx));
  end

  p_winner_set_r2: assert property (@(posedge clk) disable iff (rst)
    found |-> pending[idx]);
  p_nothing_lower_r2: assert property (@(posedge clk) disable iff (rst)
    found |-> ((pending & below) == '0));
  p_none_means_empty_r4: assert property (@(posedge clk) disable iff (rst)
    !found |-> (pending == '0));
endmodule

// File: rtl/ivo_format.sv
module ivo_format
  import ivo_pkg::*;
#(
  parameter int NLINES = 32,
  localparam int IDXW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            found,
  input  logic [IDXW-1:0] idx,
  input  logic            ie,
  output logic [31:0]     value
);
  logic [31:0] offset;

  always_comb begin
    offset = '0;
    offset[IDXW+2:3] = idx;
    value = (found && ie) ? offset : NO_IRQ_CODE;
  end

  p_offset_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    (found && ie) |-> (value[2:0] == 3'b000 && value <= 32'd248));
  p_masked_by_ie_r5: assert property (@(posedge clk) disable iff (rst)
    !ie |-> (value == 32'hFFFF_FFFF));
endmodule

// File: rtl/ivo_vector_encoder.sv
module ivo_vector_encoder #(
  parameter int         NLINES = 32,
  parameter logic [7:0] SEL    = 8'h00,
  localparam int IDXW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       instr,
  input  logic [NLINES-1:0] irq_req,
  input  logic [NLINES-1:0] irq_mask,
  input  logic              saved_ie,
  output logic              done,
  output logic [31:0]       result,
  output logic [4:0]        wr_index
);
  logic              hit;
  logic [4:0]        dst;
  logic [NLINES-1:0] pending;
  logic              found;
  logic [IDXW-1:0]   idx;
  logic [31:0]       value;

  assign pending = irq_req & irq_mask;

  ivo_decode #(.SEL(SEL)) u_dec (
    .clk(clk), .rst(rst), .instr(instr), .hit(hit), .dst(dst)
  );

  ivo_prio #(.NLINES(NLINES)) u_prio (
    .clk(clk), .rst(rst), .pending(pending), .found(found), .idx(idx)
  );

  ivo_format #(.NLINES(NLINES)) u_fmt (
    .clk(clk), .rst(rst), .found(found), .idx(idx), .ie(saved_ie), .value(value)
  );

  always_comb begin
    done     = start && hit && !rst;
    result   = done ? value : '0;
    wr_index = done ? dst : '0;
  end

  p_done_needs_start_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> start);
  p_no_irq_negative_r4: assert property (@(posedge clk) disable iff (rst)
    (done && ((irq_req & irq_mask) == '0)) |-> (result == 32'hFFFF_FFFF));
  p_unmasked_line_r1: assert property (@(posedge clk) disable iff (rst)
    (done && !result[31]) |-> (irq_mask[result[IDXW+2:3]] && irq_req[result[IDXW+2:3]]));
  p_dest_field_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (wr_index == instr[21:17]));
endmodule

// File: tb/ivo_vector_encoder_test.sv
module ivo_vector_encoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0;
  logic [31:0] instr = 0, req = 0, msk = 0;
  logic        ie = 0;
  logic        done;
  logic [31:0] result;
  logic [4:0]  wr_index;

  logic        start5 = 0;
  logic [31:0] instr5 = 0;
  logic [4:0]  req5 = 0, msk5 = 0;
  logic        ie5 = 0;
  logic        done5;
  logic [31:0] result5;
  logic [4:0]  wr5;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivo_vector_encoder #(.NLINES(32), .SEL(8'h2A)) uut (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .irq_req(req),
    .irq_mask(msk), .saved_ie(ie), .done(done), .result(result), .wr_index(wr_index));

  ivo_vector_encoder #(.NLINES(5), .SEL(8'h03)) uut5 (
    .clk(clk), .rst(rst), .start(start5), .instr(instr5), .irq_req(req5),
    .irq_mask(msk5), .saved_ie(ie5), .done(done5), .result(result5), .wr_index(wr5));

  function automatic logic [31:0] mk(logic [5:0] op, logic [7:0] sel, logic [2:0] fl,
                                     logic [4:0] rc, logic [4:0] ra, logic [4:0] rb);
    return {ra, rb, rc, fl, sel, op};
  endfunction

  function automatic logic [31:0] expect_res(logic [31:0] p, bit e, int n);
    if (!e) return 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) if (p[i]) return 32'(8 * i);
    return 32'hFFFF_FFFF;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run32(logic [31:0] ins, logic [31:0] r, logic [31:0] m, bit e,
                       bit s, string tag);
    bit hit;
    @(negedge clk);
    instr = ins; req = r; msk = m; ie = e; start = s;
    #1;
    hit = s && ins[5:0] == 6'h32 && ins[13:6] == 8'h2A && ins[16:14] == 3'b001;
    chk({tag, " done"}, 32'(done), 32'(hit));
    chk({tag, " result"}, result, hit ? expect_res(r & m, e, 32) : 32'h0);
    chk({tag, " R8 wr_index"}, 32'(wr_index), hit ? 32'(ins[21:17]) : 32'h0);
  endtask

  task automatic run5(logic [31:0] ins, logic [4:0] r, logic [4:0] m, bit e, string tag);
    @(negedge clk);
    instr5 = ins; req5 = r; msk5 = m; ie5 = e; start5 = 1;
    #1;
    chk({tag, " done5"}, 32'(done5), 32'(1));
    chk({tag, " result5"}, result5, expect_res(32'(r & m), e, 5));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] good;
    void'($urandom(32'd1234));
    good = mk(6'h32, 8'h2A, 3'b001, 5'd9, 5'd0, 5'd0);

    // R10: reset holds outputs low even with matching start
    @(negedge clk);
    instr = good; req = 32'h1; msk = 32'h1; ie = 1; start = 1;
    #1;
    chk("R10 done in reset", 32'(done), 32'h0);
    chk("R10 result in reset", result, 32'h0);
    @(negedge clk); rst = 0; start = 0;

    // R9: no start
    run32(good, 32'h10, 32'hFFFF_FFFF, 1, 0, "R9 idle");
    // R3 extremes
    run32(good, 32'h1, 32'hFFFF_FFFF, 1, 1, "R3 line0");
    run32(good, 32'h8000_0000, 32'hFFFF_FFFF, 1, 1, "R3 line31");
    // R2 lowest wins
    run32(good, 32'hF0F0_0300, 32'hFFFF_FFFF, 1, 1, "R2 multi");
    // R1 masking
    run32(good, 32'h0000_0303, 32'hFFFF_FFFC, 1, 1, "R1 mask");
    // R4 none pending
    run32(good, 32'hFFFF_0000, 32'h0000_FFFF, 1, 1, "R4 empty");
    // R5 ie clear
    run32(good, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, "R5 ie off");
    // R6 single bit flips in opcode, selector, flags
    run32(good ^ 32'h1, 32'h4, 32'hFFFF_FFFF, 1, 1, "R6 opcode");
    run32(good ^ 32'h40, 32'h4, 32'hFFFF_FFFF, 1, 1, "R6 sel");
    run32(good ^ 32'h4000, 32'h4, 32'hFFFF_FFFF, 1, 1, "R6 flag writeC");
    run32(good ^ 32'h1_0000, 32'h4, 32'hFFFF_FFFF, 1, 1, "R6 flag readA");
    // R7 source fields ignored
    run32(mk(6'h32, 8'h2A, 3'b001, 5'd31, 5'd17, 5'd5), 32'h20, 32'hFFFF_FFFF, 1, 1,
          "R7 src fields");

    // random mix on the 32-line copy
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ins;
      ins = mk(($urandom % 4 == 0) ? 6'($urandom) : 6'h32,
               ($urandom % 4 == 0) ? 8'($urandom) : 8'h2A,
               ($urandom % 5 == 0) ? 3'($urandom) : 3'b001,
               5'($urandom), 5'($urandom), 5'($urandom));
      run32(ins, $urandom & $urandom, $urandom | $urandom, ($urandom % 6) != 0,
            ($urandom % 8) != 0, "R1 R2 R3 random");
    end

    // 5-line copy
    run5(mk(6'h32, 8'h03, 3'b001, 5'd1, 5'd0, 5'd0), 5'b10000, 5'b11111, 1, "R3 top5");
    run5(mk(6'h32, 8'h03, 3'b001, 5'd1, 5'd0, 5'd0), 5'b10110, 5'b11011, 1, "R2 five");
    run5(mk(6'h32, 8'h03, 3'b001, 5'd1, 5'd0, 5'd0), 5'b00000, 5'b11111, 1, "R4 five");
    for (int k = 0; k < 100; k++)
      run5(mk(6'h32, 8'h03, 3'b001, 5'($urandom), 5'($urandom), 5'($urandom)),
           5'($urandom), 5'($urandom), ($urandom % 5) != 0, "R5 random five");

    @(negedge clk); start = 0; start5 = 0;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule